// File: doc/BRIEF.md
# Coincident-Edge Sync Pulse Generator

This block runs on the VCO clock of a clock-distribution PLL. It sits beside the output divider bank. The bank makes two divided clocks, called the A clock and the C clock, and their ratios are not always integer multiples of each other. The block drives an active-low warning line, `sync_n`. The line falls one period of the faster divided clock before the next cycle in which both divided clocks rise together. It rises again exactly in that shared rising cycle. Downstream logic uses the line to line up transfers between the two clock domains.

The block takes the same select codes as the divider bank. A two-bit code chooses each ratio, and a range bit doubles both ratios when the VCO is run at twice the rate. The block is reset together with the dividers, so both divided clocks rise in the first VCO cycle after reset release. From that cycle the block keeps a phase counter modulo the least common multiple of the two ratios. A change of the select inputs is held back until the next shared rising cycle. This means a frame is never cut short or stretched.

Top module: `sync_pulse_gen`

## Requirements
- R1: While `rst_n` is low, and until the first rising clock edge after release, `sync_n` is high.
- R2: The A ratio, in VCO cycles, is 4, 6, 8 or 12 for `sel_a` codes 0, 1, 2 and 3 when `vco_full` is 1. It is twice that when `vco_full` is 0.
- R3: The C ratio, in VCO cycles, is 2, 4, 6 or 8 for `sel_c` codes 0, 1, 2 and 3 when `vco_full` is 1. It is twice that when `vco_full` is 0.
- R4: Shared rising cycles, at phase 0, occur in the first clock cycle after reset release and then every L cycles, where L is the least common multiple of the two ratios. The frame pattern of `sync_n` repeats with period L.
- R5: With unequal ratios, `sync_n` is low for exactly min(A ratio, C ratio) cycles in each frame, covering phases L-min to L-1. It is high in the phase-0 cycle.
- R6: With equal ratios, every rising edge is shared, so `sync_n` stays low continuously once the first post-reset cycle has begun.
- R7: A pulse is produced even when one ratio is an integer multiple of the other.
- R8: A change of `vco_full`, `sel_a` or `sel_c` partway through a frame does not alter the timing of that frame. The new ratios govern from the next phase-0 cycle onward.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | VCO clock |
| rst_n | input | 1 | Asynchronous active-low reset, shared with the divider bank |
| vco_full | input | 1 | 1: base ratios; 0: both ratios doubled |
| sel_a | input | 2 | A clock ratio code |
| sel_c | input | 2 | C clock ratio code |
| sync_n | output | 1 | Registered active-low coincidence warning |

## Verification
The assertions assume that the select inputs hold defined values whenever reset is released. They also assume that the divider bank leaves reset on the same edge, so that phase 0 is a shared rising cycle. Under these assumptions, the least common multiple of the sampled ratios is always a multiple of both. The stimulus drives the select inputs before reset is released, and it changes them only on falling clock edges. One directed run changes the selects partway through a frame. This covers the one case where the stored frame and the candidate frame differ, and lets the frame-hold and edge-placement properties be checked across a reload.

// File: rtl/sync_pkg.sv
package sync_pkg;

  localparam int unsigned SEL_W     = 2;
  localparam int unsigned CNT_W     = 6;
  localparam int unsigned GCD_STEPS = 12;

  typedef logic [CNT_W-1:0] cyc_t;

  typedef struct packed {
    cyc_t span;   // cycles between shared rising edges
    cyc_t lead;   // phase at which the warning starts
  } frame_t;

  function automatic cyc_t qa_base(input logic [SEL_W-1:0] code);
    case (code)
      2'd0:    return cyc_t'(4);
      2'd1:    return cyc_t'(6);
      2'd2:    return cyc_t'(8);
      default: return cyc_t'(12);
    endcase
  endfunction

  function automatic cyc_t qc_base(input logic [SEL_W-1:0] code);
    case (code)
      2'd0:    return cyc_t'(2);
      2'd1:    return cyc_t'(4);
      2'd2:    return cyc_t'(6);
      default: return cyc_t'(8);
    endcase
  endfunction

  function automatic cyc_t range_scale(input cyc_t r, input logic full);
    return full ? r : {r[CNT_W-2:0], 1'b0};
  endfunction

  function automatic cyc_t gcd_of(input cyc_t x, input cyc_t y);
    cyc_t a;
    cyc_t b;
    cyc_t t;
    a = x;
    b = y;
    for (int i = 0; i < GCD_STEPS; i++) begin
      if (b != '0) begin
        t = a % b;
        a = b;
        b = t;
      end
    end
    return a;
  endfunction

  function automatic cyc_t lcm_of(input cyc_t x, input cyc_t y);
    cyc_t g;
    g = gcd_of(x, y);
    if (g == '0) return '0;
    return cyc_t'((x / g) * y);
  endfunction

  function automatic cyc_t min_of(input cyc_t x, input cyc_t y);
    return (x < y) ? x : y;
  endfunction

endpackage

// File: rtl/sync_ratio_dec.sv
module sync_ratio_dec
  import sync_pkg::*;
(
  input  logic             vco_full,
  input  logic [SEL_W-1:0] sel_a,
  input  logic [SEL_W-1:0] sel_c,
  output cyc_t             ratio_a,
  output cyc_t             ratio_c,
  output frame_t           frame
);

  cyc_t fast_per;

  always_comb begin
    ratio_a    = range_scale(qa_base(sel_a), vco_full);
    ratio_c    = range_scale(qc_base(sel_c), vco_full);
    fast_per   = min_of(ratio_a, ratio_c);
    frame.span = lcm_of(ratio_a, ratio_c);
    frame.lead = frame.span - fast_per;
  end

endmodule

// File: rtl/sync_phase_ctr.sv
module sync_phase_ctr
  import sync_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  frame_t frame_in,
  output logic   live_q,
  output cyc_t   cnt_q,
  output frame_t frame_q,
  output logic   live_d,
  output cyc_t   cnt_d,
  output frame_t frame_d
);

  // internal events, named for the checks
  logic at_last;
  logic arm_evt;

  assign at_last = live_q && (cnt_q == frame_q.span - cyc_t'(1));
  assign arm_evt = !live_q;

  always_comb begin
    live_d  = 1'b1;
    cnt_d   = cnt_q + cyc_t'(1);
    frame_d = frame_q;
    if (arm_evt || at_last) begin
      cnt_d   = '0;
      frame_d = frame_in;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      live_q  <= 1'b0;
      cnt_q   <= '0;
      frame_q <= '0;
    end else begin
      live_q  <= live_d;
      cnt_q   <= cnt_d;
      frame_q <= frame_d;
    end
  end

  // R4
  cnt_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    live_q |-> (cnt_q < frame_q.span));

  // R8
  frame_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (live_q && !at_last) |=> $stable(frame_q));

  // R4
  wrap_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    at_last |=> (cnt_q == '0));

endmodule

// File: rtl/sync_shaper.sv
module sync_shaper
  import sync_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic live_d,
  input  cyc_t cnt_d,
  input  cyc_t lead_d,
  output logic sync_n
);

  logic warn_zone;

  assign warn_zone = live_d && (cnt_d >= lead_d);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_n <= 1'b1;
    else        sync_n <= !warn_zone;
  end

endmodule

// File: rtl/sync_pulse_gen.sv
module sync_pulse_gen
  import sync_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             vco_full,
  input  logic [SEL_W-1:0] sel_a,
  input  logic [SEL_W-1:0] sel_c,
  output logic             sync_n
);

  cyc_t   ratio_a;
  cyc_t   ratio_c;
  frame_t frame_c;
  logic   live_q;
  cyc_t   cnt_q;
  frame_t frame_q;
  logic   live_d;
  cyc_t   cnt_d;
  frame_t frame_d;

  sync_ratio_dec u_dec (
    .vco_full (vco_full),
    .sel_a    (sel_a),
    .sel_c    (sel_c),
    .ratio_a  (ratio_a),
    .ratio_c  (ratio_c),
    .frame    (frame_c)
  );

  sync_phase_ctr u_ctr (
    .clk      (clk),
    .rst_n    (rst_n),
    .frame_in (frame_c),
    .live_q   (live_q),
    .cnt_q    (cnt_q),
    .frame_q  (frame_q),
    .live_d   (live_d),
    .cnt_d    (cnt_d),
    .frame_d  (frame_d)
  );

  sync_shaper u_shp (
    .clk    (clk),
    .rst_n  (rst_n),
    .live_d (live_d),
    .cnt_d  (cnt_d),
    .lead_d (frame_d.lead),
    .sync_n (sync_n)
  );

  // R1
  idle_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !live_q |-> sync_n);

  // R5
  rise_at_coin_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sync_n) |-> (cnt_q == '0));

  // R5
  fall_at_lead_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(sync_n) |-> (cnt_q == frame_q.lead));

  // R6
  equal_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (live_q && frame_q.lead == '0) |-> !sync_n);

  // R2 R3
  span_mult_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((frame_c.span % ratio_a) == '0) && ((frame_c.span % ratio_c) == '0));

endmodule

// File: tb/sync_pulse_gen_test.sv
module sync_pulse_gen_test;

  localparam int CLK_PERIOD = 10;
  localparam int NVEC = 8;
  // {vco_full, sel_a, sel_c, expected span, expected low width}
  localparam logic [16:0] VEC [NVEC] = '{
    {1'b1, 2'd0, 2'd0, 6'd4,  6'd2},
    {1'b1, 2'd1, 2'd3, 6'd24, 6'd6},
    {1'b1, 2'd3, 2'd2, 6'd12, 6'd6},
    {1'b1, 2'd2, 2'd1, 6'd8,  6'd4},
    {1'b0, 2'd1, 2'd3, 6'd48, 6'd12},
    {1'b0, 2'd3, 2'd2, 6'd24, 6'd12},
    {1'b0, 2'd0, 2'd1, 6'd8,  6'd8},
    {1'b1, 2'd3, 2'd3, 6'd24, 6'd8}
  };

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       vco_full = 1'b1;
  logic [1:0] sel_a = 2'd0;
  logic [1:0] sel_c = 2'd0;
  logic       sync_n;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  // bench model state
  bit m_live = 1'b0;
  int m_cnt = 0;
  int m_span = 0;
  int m_lead = 0;
  bit m_sync = 1'b1;

  sync_pulse_gen uut (
    .clk      (clk),
    .rst_n    (rst_n),
    .vco_full (vco_full),
    .sel_a    (sel_a),
    .sel_c    (sel_c),
    .sync_n   (sync_n)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic int ra(input logic [1:0] c, input logic full);
    int r;
    r = (c < 2) ? 4 + 2 * int'(c) : 8 + 4 * (int'(c) - 2);
    return full ? r : 2 * r;
  endfunction

  function automatic int rc(input logic [1:0] c, input logic full);
    int r;
    r = 2 * (int'(c) + 1);
    return full ? r : 2 * r;
  endfunction

  function automatic int common_span(input int x, input int y);
    for (int k = 1; k <= 256; k++)
      if ((k % x) == 0 && (k % y) == 0) return k;
    return 0;
  endfunction

  always @(posedge clk) begin
    int na, nc;
    if (!rst_n) begin
      m_live = 1'b0; m_cnt = 0; m_span = 0; m_lead = 0; m_sync = 1'b1;
    end else begin
      if (!m_live || m_cnt == m_span - 1) begin
        na = ra(sel_a, vco_full);
        nc = rc(sel_c, vco_full);
        m_span = common_span(na, nc);
        m_lead = m_span - ((na < nc) ? na : nc);
        m_cnt = 0;
        m_live = 1'b1;
      end else begin
        m_cnt = m_cnt + 1;
      end
      m_sync = !(m_cnt >= m_lead);
    end
  end

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic report();
    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  endtask

  task automatic do_reset();
    @(negedge clk) rst_n = 1'b0;
    @(negedge clk);
    chk("R1 high in reset", int'(sync_n), 1);
    @(negedge clk);
    rst_n = 1'b1;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    report();
  end

  initial begin
    int span, width, low_cnt, at_coin;
    string tag;
    // table walk
    for (int v = 0; v < NVEC; v++) begin
      {vco_full, sel_a, sel_c} = VEC[v][16:12];
      span  = int'(VEC[v][11:6]);
      width = int'(VEC[v][5:0]);
      do_reset();
      low_cnt = 0;
      at_coin = 1;
      for (int j = 1; j <= 2 * span + 2; j++) begin
        @(negedge clk);
        chk("R4/R5 cycle model", int'(sync_n), int'(m_sync));
        if (j <= span && !sync_n) low_cnt++;
        if (j == span + 1) at_coin = int'(sync_n);
      end
      if (width == span) begin
        chk("R6 equal ratios low count", low_cnt, span);
        chk("R6 equal ratios low at coincidence", at_coin, 0);
      end else begin
        tag = (span == width * (span / width) && (v == 0 || v == 3 || v == 5))
              ? "R7 integer pair width" : "R2/R3/R5 low width";
        chk(tag, low_cnt, width);
        chk("R4 high at repeat coincidence", at_coin, 1);
      end
    end

    // R8: change selects partway through a frame (8/4 frame -> 24/6)
    {vco_full, sel_a, sel_c} = {1'b1, 2'd2, 2'd1};
    do_reset();
    for (int j = 1; j <= 40; j++) begin
      @(negedge clk);
      chk("R8 cycle model", int'(sync_n), int'(m_sync));
      if (j == 3) {vco_full, sel_a, sel_c} = {1'b1, 2'd1, 2'd3};
      if (j == 4)  chk("R8 old frame before lead", int'(sync_n), 1);
      if (j == 5)  chk("R8 old lead kept", int'(sync_n), 0);
      if (j == 9)  chk("R8 high at old coincidence", int'(sync_n), 1);
      if (j == 26) chk("R8 new frame before lead", int'(sync_n), 1);
      if (j == 27) chk("R8 new lead applied", int'(sync_n), 0);
      if (j == 33) chk("R8 high at new coincidence", int'(sync_n), 1);
    end

    // R1: first cycle after release stays high on an unequal pair
    {vco_full, sel_a, sel_c} = {1'b1, 2'd3, 2'd0};
    do_reset();
    @(negedge clk);
    chk("R1 first live cycle high", int'(sync_n), 1);
    report();
  end

endmodule